// File: doc/BRIEF.md
# Debuggee Clock and Signal Controller

This block sits between a free-running source clock, the input bits meant for a device under test, and that device. It drives a gated clock and a registered copy of the device's inputs. Three command pulses (run, halt, step) decide when clock edges reach the device. A step delivers a single rising edge and then stops. While the device is stopped, its inputs stay frozen, so the controller can inspect them or override them bit by bit before the next edge.

The device's outputs come back into a masked equality comparator. When the comparator is armed and matches during a run, it does one of two things. It can stop the device clock before the next edge, which works as a hardware breakpoint. It can instead switch a chosen set of input bits to trigger values while the clock keeps running. A cut function can also break the clock path or any input bit, either for a set number of source cycles or until it is cleared. Stepping works only because the device takes its clock from this block; a device that makes its own clock internally cannot be stepped.

Top module: `dbg_clk_ctrl`

## Requirements
- R1: After reset the status is halted (`status` = 2'b00), `dev_in` is all zeros, no cut is active and no `dev_clk` edge occurs.
- R2: While halted, `dev_clk` stays low and `dev_in` keeps its value even when `dev_in_raw` changes.
- R3: A step command issued while halted gives exactly one rising edge on `dev_clk`, then the status returns to halted. `dev_in` then shows the raw value captured on that edge.
- R4: Run gives a continuous edge on every source cycle and halt stops it. Halt takes priority over step, and step takes priority over run. A step or run issued while running has no effect; the status stays 2'b01.
- R5: For each bit where `ovr_en` is 1, `dev_in` shows the matching `ovr_value` bit at once, including while halted. The other bits show the held value.
- R6: In halt-on-match mode (`cond_act_ovr` = 0), armed by `cond_en`, the first `dev_out` value that meets (dev_out & cond_mask) == (cond_value & cond_mask) during a run gets no further edge. The status becomes triggered (2'b10) and `dev_out` keeps the matching value.
- R7: In substitute mode (`cond_act_ovr` = 1), a match during a run makes every bit set in `trig_mask` show `trig_value`. The clock keeps running, and the substitution stays until `cond_en` goes low.
- R8: With `cond_en` low, a matching `dev_out` causes neither a halt nor a substitution.
- R9: A `cut_start` with a nonzero `cut_len` and `cut_clk_sel` set removes exactly `cut_len` consecutive device edges from a run.
- R10: A `cut_start` with `cut_len` = 0 holds the cut until `cut_clear`. Input bits chosen by `cut_in_sel` read 0 on `dev_in` while the cut is active. Precedence on `dev_in`, highest first: cut, substitution, manual override, held value.
- R11: The gated clock is glitch-free. Every `dev_clk` pulse begins with a rising edge of `src_clk` and lasts a full high phase of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_run | input | 1 | Resume command pulse |
| cmd_halt | input | 1 | Halt command pulse |
| cmd_step | input | 1 | Single-edge step command pulse |
| cond_en | input | 1 | Arms the comparator |
| cond_act_ovr | input | 1 | Match action: 0 halt, 1 substitute inputs |
| cond_mask | input | OUT_W | Compare mask on watched outputs |
| cond_value | input | OUT_W | Compare value |
| trig_mask | input | IN_W | Input bits substituted on a match |
| trig_value | input | IN_W | Values used for substitution |
| ovr_en | input | IN_W | Manual per-bit override enable |
| ovr_value | input | IN_W | Manual override values |
| cut_start | input | 1 | Starts a cut with the current selection |
| cut_clear | input | 1 | Ends any cut (wins over start) |
| cut_len | input | CNT_W | Cut length in source cycles, 0 = until cleared |
| cut_clk_sel | input | 1 | Cut applies to the device clock |
| cut_in_sel | input | IN_W | Input bits forced to 0 by the cut |
| dev_in_raw | input | IN_W | Real input values meant for the device |
| dev_out | input | OUT_W | Device outputs watched by the comparator |
| dev_clk | output | 1 | Gated clock to the device |
| dev_in | output | IN_W | Inputs driven to the device |
| status | output | 2 | 00 halted, 01 running, 10 halted by match |

## Verification
The bench builds the block with IN_W = 8, OUT_W = 8 and CNT_W = 8. It feeds `dev_out` from an 8-bit counter clocked by `dev_clk`, so every edge the block lets through moves the watched value, and breakpoint and substitution points can be placed a few edges ahead of the current count. A cut length of 4 against an 8-bit length counter covers the timed and the held cut within a short run. Eight input bits are enough for mixed override patterns, where manual, substituted, cut and held bits all show up on the same `dev_in` word.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [1:0] {
    ST_HALT = 2'b00,
    ST_RUN  = 2'b01,
    ST_STEP = 2'b10
  } run_state_e;

  localparam logic [1:0] STAT_HALTED    = 2'b00;
  localparam logic [1:0] STAT_RUNNING   = 2'b01;
  localparam logic [1:0] STAT_TRIGGERED = 2'b10;
endpackage

// File: rtl/dbg_run_fsm.sv
module dbg_run_fsm
  import dbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_run,
  input  logic       cmd_halt,
  input  logic       cmd_step,
  input  logic       stop_hit,
  output run_state_e state_o,
  output logic       trig_o
);
  run_state_e state_q, state_d;
  logic       trig_q, trig_d;

  always_comb begin
    state_d = state_q;
    trig_d  = trig_q;
    unique case (state_q)
      ST_HALT: begin
        if (cmd_halt) begin
          state_d = ST_HALT;
        end else if (cmd_step) begin
          state_d = ST_STEP;
          trig_d  = 1'b0;
        end else if (cmd_run) begin
          state_d = ST_RUN;
          trig_d  = 1'b0;
        end
      end
      ST_RUN: begin
        if (cmd_halt) begin
          state_d = ST_HALT;
        end else if (stop_hit) begin
          state_d = ST_HALT;
          trig_d  = 1'b1;
        end
      end
      ST_STEP: state_d = ST_HALT;
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HALT;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      trig_q  <= trig_d;
    end
  end

  assign state_o = state_q;
  assign trig_o  = trig_q;

  AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP) |=> (state_q == ST_HALT)); // R3

  AST_HALT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_halt |=> (state_q == ST_HALT)); // R4
endmodule

// File: rtl/dbg_cond_cmp.sv
module dbg_cond_cmp #(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cond_en,
  input  logic             act_ovr,
  input  logic             live,
  input  logic [OUT_W-1:0] watched,
  input  logic [OUT_W-1:0] mask,
  input  logic [OUT_W-1:0] value,
  output logic             hit_halt,
  output logic             ovr_act
);
  logic [OUT_W-1:0] diff;
  logic             match;
  logic             ovr_q;

  genvar b;
  generate
    for (b = 0; b < OUT_W; b++) begin : g_bit
      assign diff[b] = mask[b] & (watched[b] ^ value[b]);
    end
  endgenerate

  assign match    = cond_en & ~(|diff);
  assign hit_halt = match & ~act_ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
    end else if (!cond_en) begin
      ovr_q <= 1'b0;
    end else if (match && act_ovr && live) begin
      ovr_q <= 1'b1;
    end
  end

  assign ovr_act = ovr_q;
endmodule

// File: rtl/dbg_cut_timer.sv
module dbg_cut_timer #(
  parameter int IN_W  = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cut_start,
  input  logic             cut_clear,
  input  logic [CNT_W-1:0] cut_len,
  input  logic             sel_clk,
  input  logic [IN_W-1:0]  sel_in,
  output logic             clk_cut,
  output logic [IN_W-1:0]  in_cut
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic             active_q;
  logic [CNT_W-1:0] left_q;
  logic             sel_clk_q;
  logic [IN_W-1:0]  sel_in_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      left_q    <= '0;
      sel_clk_q <= 1'b0;
      sel_in_q  <= '0;
    end else if (cut_clear) begin
      active_q <= 1'b0;
      left_q   <= '0;
    end else if (cut_start) begin
      active_q  <= 1'b1;
      left_q    <= cut_len;
      sel_clk_q <= sel_clk;
      sel_in_q  <= sel_in;
    end else if (active_q && (left_q != '0)) begin
      if (left_q == LAST) begin
        active_q <= 1'b0;
        left_q   <= '0;
      end else begin
        left_q <= left_q - LAST;
      end
    end
  end

  assign clk_cut = active_q & sel_clk_q;
  assign in_cut  = active_q ? sel_in_q : '0;

  AST_CUT_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_start && !cut_clear && (cut_len != '0) && sel_clk) |=> clk_cut); // R9
endmodule

// File: rtl/dbg_clk_gate.sv
module dbg_clk_gate (
  input  logic src_clk,
  input  logic rst_n,
  input  logic enable,
  output logic gclk,
  output logic edge_q
);
  logic en_low_q;

  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) en_low_q <= 1'b0;
    else        en_low_q <= enable;
  end

  assign gclk   = src_clk & en_low_q;
  assign edge_q = en_low_q;
endmodule

// File: rtl/dbg_clk_ctrl.sv
module dbg_clk_ctrl
  import dbg_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8,
  parameter int CNT_W = 8
) (
  input  logic             src_clk,
  input  logic             rst_n,
  input  logic             cmd_run,
  input  logic             cmd_halt,
  input  logic             cmd_step,
  input  logic             cond_en,
  input  logic             cond_act_ovr,
  input  logic [OUT_W-1:0] cond_mask,
  input  logic [OUT_W-1:0] cond_value,
  input  logic [IN_W-1:0]  trig_mask,
  input  logic [IN_W-1:0]  trig_value,
  input  logic [IN_W-1:0]  ovr_en,
  input  logic [IN_W-1:0]  ovr_value,
  input  logic             cut_start,
  input  logic             cut_clear,
  input  logic [CNT_W-1:0] cut_len,
  input  logic             cut_clk_sel,
  input  logic [IN_W-1:0]  cut_in_sel,
  input  logic [IN_W-1:0]  dev_in_raw,
  input  logic [OUT_W-1:0] dev_out,
  output logic             dev_clk,
  output logic [IN_W-1:0]  dev_in,
  output logic [1:0]       status
);
  run_state_e      state;
  logic            trig_halted;
  logic            hit_halt;
  logic            subst_act;
  logic            clk_cut;
  logic [IN_W-1:0] in_cut;
  logic            gate_en;
  logic            dev_edge;
  logic [IN_W-1:0] held_q;
  logic            live;

  assign live = (state == ST_RUN);

  dbg_run_fsm u_fsm (
    .clk      (src_clk),
    .rst_n    (rst_n),
    .cmd_run  (cmd_run),
    .cmd_halt (cmd_halt),
    .cmd_step (cmd_step),
    .stop_hit (hit_halt),
    .state_o  (state),
    .trig_o   (trig_halted)
  );

  dbg_cond_cmp #(.OUT_W(OUT_W)) u_cmp (
    .clk      (src_clk),
    .rst_n    (rst_n),
    .cond_en  (cond_en),
    .act_ovr  (cond_act_ovr),
    .live     (live),
    .watched  (dev_out),
    .mask     (cond_mask),
    .value    (cond_value),
    .hit_halt (hit_halt),
    .ovr_act  (subst_act)
  );

  dbg_cut_timer #(.IN_W(IN_W), .CNT_W(CNT_W)) u_cut (
    .clk       (src_clk),
    .rst_n     (rst_n),
    .cut_start (cut_start),
    .cut_clear (cut_clear),
    .cut_len   (cut_len),
    .sel_clk   (cut_clk_sel),
    .sel_in    (cut_in_sel),
    .clk_cut   (clk_cut),
    .in_cut    (in_cut)
  );

  // a matching output blocks the very next edge, so the device stops on it
  assign gate_en = ((live & ~hit_halt) | (state == ST_STEP)) & ~clk_cut;

  dbg_clk_gate u_gate (
    .src_clk (src_clk),
    .rst_n   (rst_n),
    .enable  (gate_en),
    .gclk    (dev_clk),
    .edge_q  (dev_edge)
  );

  // inputs advance only on posedges where the device also sees an edge
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n)        held_q <= '0;
    else if (dev_edge) held_q <= dev_in_raw;
  end

  genvar i;
  generate
    for (i = 0; i < IN_W; i++) begin : g_in
      always_comb begin
        if (in_cut[i])                     dev_in[i] = 1'b0;
        else if (subst_act & trig_mask[i]) dev_in[i] = trig_value[i];
        else if (ovr_en[i])                dev_in[i] = ovr_value[i];
        else                               dev_in[i] = held_q[i];
      end
    end
  endgenerate

  always_comb begin
    if (state == ST_HALT) status = trig_halted ? STAT_TRIGGERED : STAT_HALTED;
    else                  status = STAT_RUNNING;
  end

  AST_NO_EDGE_HALTED: assert property (@(posedge src_clk) disable iff (!rst_n)
    ((state == ST_HALT) && $past(state == ST_HALT)) |-> !dev_edge); // R2

  AST_MATCH_STOPS: assert property (@(posedge src_clk) disable iff (!rst_n)
    (live && hit_halt && !cmd_halt) |=> (status == STAT_TRIGGERED)); // R6
endmodule

// File: tb/dbg_clk_ctrl_tb.sv
module dbg_clk_ctrl_tb_top;
  localparam int IN_W  = 8;
  localparam int OUT_W = 8;
  localparam int CNT_W = 8;

  logic             src_clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_run = 0, cmd_halt = 0, cmd_step = 0;
  logic             cond_en = 0, cond_act_ovr = 0;
  logic [OUT_W-1:0] cond_mask = '0, cond_value = '0;
  logic [IN_W-1:0]  trig_mask = '0, trig_value = '0;
  logic [IN_W-1:0]  ovr_en = '0, ovr_value = '0;
  logic             cut_start = 0, cut_clear = 0, cut_clk_sel = 0;
  logic [CNT_W-1:0] cut_len = '0;
  logic [IN_W-1:0]  cut_in_sel = '0;
  logic [IN_W-1:0]  dev_in_raw = '0;
  logic [OUT_W-1:0] dev_cnt = '0;
  logic             dev_clk;
  logic [IN_W-1:0]  dev_in;
  logic [1:0]       status;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  int glitch = 0;
  realtime rise_t = 0;

  always #5 src_clk = ~src_clk;

  dbg_clk_ctrl #(.IN_W(IN_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) dut_i (
    .src_clk(src_clk), .rst_n(rst_n),
    .cmd_run(cmd_run), .cmd_halt(cmd_halt), .cmd_step(cmd_step),
    .cond_en(cond_en), .cond_act_ovr(cond_act_ovr),
    .cond_mask(cond_mask), .cond_value(cond_value),
    .trig_mask(trig_mask), .trig_value(trig_value),
    .ovr_en(ovr_en), .ovr_value(ovr_value),
    .cut_start(cut_start), .cut_clear(cut_clear), .cut_len(cut_len),
    .cut_clk_sel(cut_clk_sel), .cut_in_sel(cut_in_sel),
    .dev_in_raw(dev_in_raw), .dev_out(dev_cnt),
    .dev_clk(dev_clk), .dev_in(dev_in), .status(status)
  );

  // device model: counter on the gated clock
  always @(posedge dev_clk) begin
    dev_cnt <= dev_cnt + 8'd1;
    edges   <= edges + 1;
    rise_t  = $realtime;
    if (src_clk !== 1'b1) glitch++;
  end
  always @(negedge dev_clk) begin
    if ($realtime - rise_t != 5.0) glitch++;
  end

  // {ovr_en, ovr_value, expected dev_in} with held value 8'hA5
  localparam logic [23:0] OVR_TBL [6] = '{
    {8'h00, 8'hFF, 8'hA5},
    {8'hFF, 8'h00, 8'h00},
    {8'h0F, 8'h3C, 8'hAC},
    {8'hF0, 8'h3C, 8'h35},
    {8'h81, 8'h7E, 8'h24},
    {8'h3C, 8'hC3, 8'h81}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge src_clk);
    #1;
  endtask

  task automatic pulse(input logic r, input logic h, input logic s);
    cmd_run = r; cmd_halt = h; cmd_step = s;
    tick(1);
    cmd_run = 0; cmd_halt = 0; cmd_step = 0;
  endtask

  initial begin
    #500us;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int e0;
    logic [7:0] c0;
    tick(3);
    rst_n = 1'b1;
    tick(5);
    chk("R1 status", status, 2'b00);
    chk("R1 dev_in", dev_in, 8'h00);
    chk("R1 edges", edges, 0);

    dev_in_raw = 8'hA5;
    tick(4);
    chk("R2 held while halted", dev_in, 8'h00);
    chk("R2 no edge", edges, 0);

    e0 = edges;
    pulse(0, 0, 1);
    tick(4);
    chk("R3 one edge", edges - e0, 1);
    chk("R3 halted again", status, 2'b00);
    chk("R3 captured", dev_in, 8'hA5);

    for (int k = 0; k < 6; k++) begin
      ovr_en = OVR_TBL[k][23:16];
      ovr_value = OVR_TBL[k][15:8];
      #1;
      chk("R5 override", dev_in, {24'd0, OVR_TBL[k][7:0]});
    end
    ovr_en = '0;

    e0 = edges;
    pulse(1, 1, 1);
    tick(4);
    chk("R4 halt wins", edges - e0, 0);
    chk("R4 halt wins status", status, 2'b00);
    pulse(1, 0, 1);
    tick(4);
    chk("R4 step over run", edges - e0, 1);
    chk("R4 step over run status", status, 2'b00);

    pulse(1, 0, 0);
    chk("R4 running", status, 2'b01);
    e0 = edges;
    tick(10);
    chk("R4 edge per cycle", edges - e0, 10);
    pulse(0, 0, 1);
    tick(2);
    chk("R4 step ignored", status, 2'b01);
    pulse(1, 0, 0);
    chk("R4 run ignored", status, 2'b01);
    pulse(0, 1, 0);
    tick(2);
    e0 = edges;
    tick(6);
    chk("R4 halt stops", edges - e0, 0);
    chk("R4 halt status", status, 2'b00);

    c0 = dev_cnt;
    cond_mask = 8'hFF; cond_value = c0 + 8'd6; cond_act_ovr = 0; cond_en = 1;
    pulse(1, 0, 0);
    tick(20);
    chk("R6 triggered", status, 2'b10);
    chk("R6 stopped on match", dev_cnt, c0 + 8'd6);
    cond_en = 0;

    c0 = dev_cnt;
    cond_value = c0 + 8'd3;
    pulse(1, 0, 0);
    tick(10);
    chk("R8 unarmed runs on", status, 2'b01);
    pulse(0, 1, 0);
    tick(2);

    dev_in_raw = 8'h00;
    c0 = dev_cnt;
    trig_mask = 8'h0F; trig_value = 8'h0A;
    cond_value = c0 + 8'd4; cond_act_ovr = 1; cond_en = 1;
    pulse(1, 0, 0);
    tick(12);
    chk("R7 substituted", dev_in, 8'h0A);
    chk("R7 still running", status, 2'b01);
    cond_en = 0;
    tick(2);
    chk("R7 released", dev_in, 8'h00);

    cut_clk_sel = 1; cut_len = 8'd4;
    e0 = edges;
    cut_start = 1;
    tick(1);
    cut_start = 0;
    tick(9);
    chk("R9 timed cut", edges - e0, 6);

    cut_len = 8'd0;
    cut_start = 1;
    tick(1);
    cut_start = 0;
    e0 = edges;
    tick(8);
    chk("R10 held cut", edges - e0, 0);
    cut_clear = 1;
    tick(1);
    cut_clear = 0;
    e0 = edges;
    tick(5);
    chk("R10 cleared", edges - e0, 5);

    dev_in_raw = 8'hFF;
    cut_clk_sel = 0; cut_in_sel = 8'h0F;
    cut_start = 1;
    tick(1);
    cut_start = 0;
    tick(2);
    chk("R10 input cut", dev_in, 8'hF0);
    cut_clear = 1;
    tick(1);
    cut_clear = 0;
    tick(1);
    chk("R10 input restored", dev_in, 8'hFF);
    pulse(0, 1, 0);
    tick(2);

    chk("R11 clean pulses", glitch, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule